// File: doc/BRIEF.md
# Command Unit and Control Block Handler

This block answers the host's attention signal for a network controller whose work is driven by descriptors held in memory. For each attention it fetches a 16-bit command word from a control block. It clears that word in memory and applies the unit commands and acknowledge bits in the word to its internal command-unit state, receive-unit state and event flags. It then writes a status word back to the head of the control block.

When the command unit is active and holds a list pointer, the block walks a linked list of action entries. It marks each entry busy and hands the entry's opcode and address to an executor over a start/done handshake. It then marks the entry complete, follows the entry's link and publishes a fresh status word. Flag bits in each entry end the list, suspend the unit or raise an interrupt.

Memory is reached through a single word request port. The request is held until an acknowledge arrives, and read data is valid in the acknowledge cycle. Pointers are 32 bits, built from two 16-bit words with the low half at the lower address.

Top module: `cmd_unit_ctl`

## Requirements
- R1: On each attention the block reads the command word at control-block offset 2, then writes 0 to that same address as its next memory access.
- R2: Command-word bits 15, 14, 13 and 12 each clear the matching event flag (CX, FR, CNA, RNR), which appear at the same positions in the status word.
- R3: A command-unit code of 1 in bits 10:8 makes the unit active (state 2). A code of 4 makes it suspended (state 1) and sets CNA. Any other code leaves the state alone.
- R4: A receive-unit code of 1 or 2 in bits 6:4 makes the receive unit ready (state 4). A code of 3 or 4 makes it suspended (state 1) and sets RNR.
- R5: Command-word bit 7 forces the command unit idle (0), the receive unit suspended and the list pointer null, after the unit codes are applied.
- R6: The status word written to offset 0 is flags in 15:12, command-unit state in 9:8 and receive-unit state in 6:4, with all other bits zero. It is written once after each command word and once after each list entry.
- R7: If the command unit is not suspended and the list pointer is null, the pointer is loaded from offsets 4 (low) and 6 (high) before the status write. A loaded value of zero counts as null.
- R8: For each entry the block writes 0x4000 to the entry address. It reads the entry word at offset 2 and pulses op_start with op_code equal to that word's bits 2:0 and op_addr equal to the entry address. It waits for op_done, then writes 0xA000 to the entry address.
- R9: The next link is read at entry offsets 4 and 6, and a zero link is null. Entry bit 15 forces the pointer null, and entry bit 14 suspends the command unit. The walk continues only while the unit is active and the pointer is not null.
- R10: Entry bit 13 sets CX and raises irq; an entry without it clears CX. irq stays high until irq_clr, and a new raise wins over a clear in the same cycle.
- R11: Each cycle with attn high counts one attention. Attentions that arrive during a pass are held, and each causes one further full pass.
- R12: After reset there is no memory request, no op_start and irq is low. The command unit is idle, the receive unit suspended, the flags zero and the pointer null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn | input | 1 | Attention from the host, one count per high cycle |
| cb_base | input | 32 | Byte address of the control block |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 16 | Read data |
| op_start | output | 1 | One-cycle start of an entry's operation |
| op_code | output | 3 | Opcode of the entry being executed |
| op_addr | output | 32 | Address of the entry being executed |
| op_done | input | 1 | Operation finished |
| irq | output | 1 | Interrupt level |
| irq_clr | input | 1 | Clears irq |

## Verification
Every internal state of this block shows up at the ports within one pass. The flag, unit-state and pointer registers reach memory in the very next status write. Each entry decision appears as the presence or absence of busy and complete writes at a given address. A wrong decode or a wrong state therefore shows as a mismatched write value or address, or as an unexpected extra write, within tens of cycles of the attention that caused it. A lost or doubled attention count shows as one pass too few or too many.

// File: rtl/cuc_pkg.sv
package cuc_pkg;
  localparam int PTR_W  = 32;
  localparam int WORD_W = 16;

  localparam logic [1:0] CU_IDLE = 2'd0;
  localparam logic [1:0] CU_SUSP = 2'd1;
  localparam logic [1:0] CU_ACT  = 2'd2;
  localparam logic [2:0] RU_SUSP  = 3'd1;
  localparam logic [2:0] RU_READY = 3'd4;

  localparam logic [PTR_W-1:0] PTR_NULL = '1;

  localparam logic [WORD_W-1:0] ENT_BUSY = 16'h4000;
  localparam logic [WORD_W-1:0] ENT_DONE = 16'hA000;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CMD, S_CLR_CMD, S_RD_LP0, S_RD_LP1, S_WR_STAT,
    S_E_BUSY, S_E_RDOP, S_E_START, S_E_WAIT, S_E_DONE, S_E_LNK0, S_E_LNK1
  } seq_t;

  function automatic logic [WORD_W-1:0] status_word(input logic [3:0] flg,
                                                    input logic [1:0] cu,
                                                    input logic [2:0] ru);
    return {flg, 2'b00, cu, 1'b0, ru, 4'b0000};
  endfunction

  function automatic logic [PTR_W-1:0] link_norm(input logic [WORD_W-1:0] hi,
                                                 input logic [WORD_W-1:0] lo);
    logic [PTR_W-1:0] p;
    p = {hi, lo};
    return (p == '0) ? PTR_NULL : p;
  endfunction
endpackage

// File: rtl/cuc_attn_cnt.sv
module cuc_attn_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic attn,
  input  logic take,
  output logic pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt;
  logic inc, dec;

  assign inc     = attn && (cnt != CNT_MAX || take);
  assign dec     = take && (cnt != '0);
  assign pending = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (inc && !dec) cnt <= cnt + 1'b1;
    else if (dec && !inc) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/cuc_scb_decode.sv
module cuc_scb_decode
  import cuc_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  input  logic [3:0]        flg_i,
  input  logic [1:0]        cu_i,
  input  logic [2:0]        ru_i,
  output logic [3:0]        flg_o,
  output logic [1:0]        cu_o,
  output logic [2:0]        ru_o,
  output logic              soft_rst
);
  always_comb begin
    flg_o = flg_i & ~cmd[15:12];
    cu_o  = cu_i;
    ru_o  = ru_i;
    unique case (cmd[10:8])
      3'd1:    cu_o = CU_ACT;
      3'd4:    begin cu_o = CU_SUSP; flg_o[1] = 1'b1; end
      default: ;
    endcase
    unique case (cmd[6:4])
      3'd1, 3'd2: ru_o = RU_READY;
      3'd3, 3'd4: begin ru_o = RU_SUSP; flg_o[0] = 1'b1; end
      default: ;
    endcase
    soft_rst = cmd[7];
    if (soft_rst) begin
      cu_o = CU_IDLE;
      ru_o = RU_SUSP;
    end
  end
endmodule

// File: rtl/cmd_unit_ctl.sv
module cmd_unit_ctl
  import cuc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 attn,
  input  logic [PTR_W-1:0]     cb_base,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [PTR_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_ack,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 op_start,
  output logic [2:0]           op_code,
  output logic [PTR_W-1:0]     op_addr,
  input  logic                 op_done,
  output logic                 irq,
  input  logic                 irq_clr
);
  seq_t              st;
  logic [3:0]        flg;
  logic [1:0]        cu;
  logic [2:0]        ru;
  logic [PTR_W-1:0]  ptr;
  logic [WORD_W-1:0] ent_q, lo_q;

  logic take;
  logic [3:0] d_flg;
  logic [1:0] d_cu;
  logic [2:0] d_ru;
  logic d_rst;

  // named events for the checker
  logic ev_cmd_read, ev_stat_wr, ev_intr, walk_go;
  logic [PTR_W-1:0] next_link;

  assign take        = (st == S_IDLE);
  assign ev_cmd_read = (st == S_RD_CMD) && mem_ack;
  assign ev_stat_wr  = (st == S_WR_STAT) && mem_req;
  assign ev_intr     = (st == S_E_LNK1) && mem_ack && ent_q[13];
  assign walk_go     = (cu == CU_ACT) && (ptr != PTR_NULL);
  assign next_link   = ent_q[15] ? PTR_NULL : link_norm(mem_rdata, lo_q);

  logic pend;
  cuc_attn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .attn(attn), .take(take && pend), .pending(pend)
  );

  cuc_scb_decode u_dec (
    .cmd(mem_rdata), .flg_i(flg), .cu_i(cu), .ru_i(ru),
    .flg_o(d_flg), .cu_o(d_cu), .ru_o(d_ru), .soft_rst(d_rst)
  );

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = cb_base;
    mem_wdata = '0;
    unique case (st)
      S_RD_CMD:  mem_addr = cb_base + 2;
      S_CLR_CMD: begin mem_addr = cb_base + 2; mem_we = 1'b1; end
      S_RD_LP0:  mem_addr = cb_base + 4;
      S_RD_LP1:  mem_addr = cb_base + 6;
      S_WR_STAT: begin mem_we = 1'b1; mem_wdata = status_word(flg, cu, ru); end
      S_E_BUSY:  begin mem_addr = ptr; mem_we = 1'b1; mem_wdata = ENT_BUSY; end
      S_E_RDOP:  mem_addr = ptr + 2;
      S_E_DONE:  begin mem_addr = ptr; mem_we = 1'b1; mem_wdata = ENT_DONE; end
      S_E_LNK0:  mem_addr = ptr + 4;
      S_E_LNK1:  mem_addr = ptr + 6;
      default:   mem_req = 1'b0;
    endcase
  end

  assign op_start = (st == S_E_START);
  assign op_code  = ent_q[2:0];
  assign op_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      flg   <= '0;
      cu    <= CU_IDLE;
      ru    <= RU_SUSP;
      ptr   <= PTR_NULL;
      ent_q <= '0;
      lo_q  <= '0;
      irq   <= 1'b0;
    end else begin
      if (ev_intr)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      unique case (st)
        S_IDLE: if (pend) st <= S_RD_CMD;
        S_RD_CMD: if (mem_ack) begin
          flg <= d_flg; cu <= d_cu; ru <= d_ru;
          if (d_rst) ptr <= PTR_NULL;
          st <= S_CLR_CMD;
        end
        S_CLR_CMD: if (mem_ack)
          st <= (cu != CU_SUSP && ptr == PTR_NULL) ? S_RD_LP0 : S_WR_STAT;
        S_RD_LP0: if (mem_ack) begin lo_q <= mem_rdata; st <= S_RD_LP1; end
        S_RD_LP1: if (mem_ack) begin
          ptr <= link_norm(mem_rdata, lo_q); st <= S_WR_STAT;
        end
        S_WR_STAT: if (mem_ack) st <= walk_go ? S_E_BUSY : S_IDLE;
        S_E_BUSY:  if (mem_ack) st <= S_E_RDOP;
        S_E_RDOP:  if (mem_ack) begin ent_q <= mem_rdata; st <= S_E_START; end
        S_E_START: st <= S_E_WAIT;
        S_E_WAIT:  if (op_done) st <= S_E_DONE;
        S_E_DONE:  if (mem_ack) st <= S_E_LNK0;
        S_E_LNK0:  if (mem_ack) begin lo_q <= mem_rdata; st <= S_E_LNK1; end
        S_E_LNK1: if (mem_ack) begin
          ptr    <= next_link;
          flg[3] <= ent_q[13];
          if (ent_q[14]) cu <= CU_SUSP;
          st <= S_WR_STAT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cuc_checker.sv
module cuc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        op_start,
  input logic        irq,
  input logic        irq_clr,
  input logic        ev_intr,
  input logic        ev_cmd_read,
  input logic        ev_stat_wr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8

  AST_CLR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_read |=> mem_req && mem_we && mem_wdata == 16'h0000); // R1

  AST_STATUS_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> mem_wdata[11:10] == 2'b00 && mem_wdata[7] == 1'b0
                   && mem_wdata[3:0] == 4'h0 && mem_wdata[9:8] != 2'b11); // R6

  AST_OP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_intr |=> irq); // R10

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !ev_intr |=> !irq); // R10
endmodule

bind cmd_unit_ctl cuc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .op_start(op_start), .irq(irq), .irq_clr(irq_clr), .ev_intr(ev_intr),
  .ev_cmd_read(ev_cmd_read), .ev_stat_wr(ev_stat_wr)
);

// File: tb/tb_cmd_unit_ctl.sv
module tb_cmd_unit_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [31:0] CB = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n, attn, irq_clr, op_done, mem_ack;
  logic mem_req, mem_we, op_start, irq;
  logic [31:0] mem_addr, op_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [2:0]  op_code;

  logic        bd_we;
  logic [31:0] bd_addr;
  logic [15:0] bd_data;
  logic [15:0] mem [0:511];

  int tot = 0, bad = 0, mtot = 0, mbad = 0;

  logic [47:0] wr_q[$];
  string       wr_tag[$];
  logic [34:0] op_q[$];
  string       op_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_unit_ctl dut (
    .clk(clk), .rst_n(rst_n), .attn(attn), .cb_base(CB),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .op_start(op_start), .op_code(op_code), .op_addr(op_addr),
    .op_done(op_done), .irq(irq), .irq_clr(irq_clr)
  );

  // memory and executor model
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      op_done <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 512; i++) mem[i] <= '0;
    end else begin
      op_done <= op_start;
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[9:1]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[9:1]];
      end
      if (bd_we) mem[bd_addr[9:1]] <= bd_data;
    end
  end

  // monitor: compares observed writes and starts with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ack) begin
      mtot++;
      if (wr_q.size() == 0) begin
        mbad++;
        $display("FAIL unexpected write R9 act=%h:%h exp=none", mem_addr, mem_wdata);
      end else begin
        logic [47:0] e;
        string t;
        e = wr_q.pop_front();
        t = wr_tag.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          mbad++;
          $display("FAIL write %s act=%h exp=%h", t, {mem_addr, mem_wdata}, e);
        end
      end
    end
    if (rst_n && op_start) begin
      mtot++;
      if (op_q.size() == 0) begin
        mbad++;
        $display("FAIL unexpected op R8 act=%h exp=none", {op_code, op_addr});
      end else begin
        logic [34:0] e;
        string t;
        e = op_q.pop_front();
        t = op_tag.pop_front();
        if ({op_code, op_addr} !== e) begin
          mbad++;
          $display("FAIL op %s act=%h exp=%h", t, {op_code, op_addr}, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic exp_wr(input logic [31:0] a, input logic [15:0] d, input string t);
    wr_q.push_back({a, d});
    wr_tag.push_back(t);
  endtask

  task automatic exp_op(input logic [2:0] c, input logic [31:0] a, input string t);
    op_q.push_back({c, a});
    op_tag.push_back(t);
  endtask

  task automatic poke(input logic [31:0] a, input logic [15:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic pulse_attn();
    @(negedge clk); attn = 1'b1;
    @(negedge clk); attn = 1'b0;
  endtask

  task automatic settle();
    int n = 0;
    while ((wr_q.size() != 0 || op_q.size() != 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic pass(input logic [15:0] cmd);
    poke(CB + 2, cmd);
    pulse_attn();
    settle();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    $display("FAIL watchdog R11 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", tot + mtot + 1, bad + mbad + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; attn = 1'b0; irq_clr = 1'b0;
    bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(mem_req == 1'b0, "R12 mem_req", 48'(mem_req), 48'h0);
    chk(irq == 1'b0, "R12 irq", 48'(irq), 48'h0);
    chk(op_start == 1'b0, "R12 op_start", 48'(op_start), 48'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R7 R8 R10: start, reload pointer, two entries, zero link ends walk
    poke(CB + 4, 16'h0200); poke(CB + 6, 16'h0000);
    poke(32'h202, 16'h0001); poke(32'h204, 16'h0240); poke(32'h206, 16'h0000);
    poke(32'h242, 16'h2004); poke(32'h244, 16'h0000); poke(32'h246, 16'h0000);
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h0210, "R3 status");
    exp_wr(32'h200, 16'h4000, "R8 busy");
    exp_op(3'd1, 32'h200, "R8 op1");
    exp_wr(32'h200, 16'hA000, "R8 done");
    exp_wr(CB, 16'h0210, "R6 entry status");
    exp_wr(32'h240, 16'h4000, "R8 busy");
    exp_op(3'd4, 32'h240, "R8 op4");
    exp_wr(32'h240, 16'hA000, "R8 done");
    exp_wr(CB, 16'h8210, "R10 CX status");
    pass(16'h0100);
    chk(irq == 1'b1, "R10 irq raised", 48'(irq), 48'h1);
    chk(mem[(CB + 2) >> 1] == 16'h0000, "R1 word cleared", 48'(mem[(CB + 2) >> 1]), 48'h0);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 irq cleared", 48'(irq), 48'h0);

    // R2 R4 R7: ack CX, receive start, reload of zero is null (no walk)
    poke(CB + 4, 16'h0000);
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h0240, "R2 R4 status");
    pass(16'h8010);

    // R3 R4: abort command unit, suspend receive unit
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h3110, "R3 R4 suspend");
    pass(16'h0430);

    // R5 R2: soft reset plus acknowledge of CNA and RNR
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h0010, "R5 soft reset");
    pass(16'h3080);

    // R9: suspend bit stops walk and keeps the link
    poke(CB + 4, 16'h0300);
    poke(32'h302, 16'h4002); poke(32'h304, 16'h0340); poke(32'h306, 16'h0000);
    poke(32'h342, 16'h8000); poke(32'h344, 16'h0380); poke(32'h346, 16'h0000);
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h0210, "R7 status");
    exp_wr(32'h300, 16'h4000, "R8 busy");
    exp_op(3'd2, 32'h300, "R8 op2");
    exp_wr(32'h300, 16'hA000, "R8 done");
    exp_wr(CB, 16'h0110, "R9 suspended");
    pass(16'h0100);
    chk(irq == 1'b0, "R10 no irq", 48'(irq), 48'h0);

    // R9: restart resumes at kept link, end-of-list bit stops walk
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h0210, "R7 no reload");
    exp_wr(32'h340, 16'h4000, "R9 resume busy");
    exp_op(3'd0, 32'h340, "R8 op0");
    exp_wr(32'h340, 16'hA000, "R9 resume done");
    exp_wr(CB, 16'h0210, "R9 eol status");
    pass(16'h0100);

    // R11: second attention during a pass gives a second pass
    poke(CB + 4, 16'h0000);
    exp_wr(CB + 2, 16'h0000, "R11 clear 1");
    exp_wr(CB, 16'h0240, "R11 status 1");
    exp_wr(CB + 2, 16'h0000, "R11 clear 2");
    exp_wr(CB, 16'h0240, "R11 status 2");
    poke(CB + 2, 16'h0010);
    pulse_attn();
    repeat (2) @(negedge clk);
    pulse_attn();
    settle();

    // R3: unknown command-unit code changes nothing
    exp_wr(CB + 2, 16'h0000, "R1 clear");
    exp_wr(CB, 16'h0240, "R3 no change");
    pass(16'h0200);

    chk(wr_q.size() == 0, "R9 writes missing", 48'(wr_q.size()), 48'h0);
    chk(op_q.size() == 0, "R8 ops missing", 48'(op_q.size()), 48'h0);
    $display("test done: total=%0d bad=%0d", tot + mtot, bad + mbad);
    $finish;
  end
endmodule